// File: doc/BRIEF.md
# Flash Upgrade Command Framer

This block sits between a byte-wide host link and a flash programming sequencer. It scans the incoming bytes for a four-character command header and reads the command that follows: program or verify. It then takes a starting block offset and a block count, checks both against the size of the flash array, and handles the command one block at a time.

For each block it passes every payload word out to a staging buffer and keeps a running additive checksum. It compares that sum with the word that closes the block. Toward the sequencer it raises a per-block request that names an operation and a block address, and holds it until the sequencer reports completion. A small status code tells a front-panel display which phase is running or which error stopped the run. An error waits for an operator button before the framer will look for a new header.

Top module: `upg_cmd_framer`

## Requirements
- R1: After reset, `status` is 0 (idle), `blk_go` and `word_valid` are low, and `rx_ready` is high.
- R2: A command starts only after the bytes 0x4D, 0x50, 0x54, 0x21 arrive in sequence. A byte that breaks the sequence is dropped, and the search restarts at the next byte, even when the dropped byte is 0x4D.
- R3: The byte after the header picks the command. 0x50 selects program and sets `status` to 1. 0x56 selects verify and sets `status` to 2. Any other value returns to the header search, and that value has no other effect.
- R4: The next four bytes form a little-endian offset. The offset must be a multiple of the block size and lower than the array size (ARRAY_BLOCKS blocks). Otherwise `status` becomes 6.
- R5: The next byte is the block count. A count of zero, or a range that runs past the end of the array, sets `status` to 7. A range that ends exactly at the end of the array is accepted.
- R6: While a block is being read, `status` is 3. Each group of four bytes is assembled little-endian into a word and appears on `word_data` with a one-cycle `word_valid` pulse, in arrival order, BLOCK_WORDS words per block.
- R7: After the payload words comes one little-endian word. If it differs from the payload sum modulo 2^32, `status` becomes 8 and no write or verify request follows.
- R8: Program mode requests an erase (`blk_op` 1, `status` 1) before it accepts the block data, then a write (`blk_op` 2, `status` 4), then a verify (`blk_op` 3, `status` 5). Verify mode issues only the verify request. `rx_ready` is low while any request is open.
- R9: `blk_go` stays high with `blk_op` and `blk_addr` unchanged until the cycle that has `blk_done` high. `blk_addr` is BASE plus the offset, and it grows by the block size (4 × BLOCK_WORDS bytes) for each later block.
- R10: When the verify request of the last counted block completes, `status` returns to 0 and a new header is accepted.
- R11: An error code stays on `status` with `rx_ready` low for as long as `btn` is low. The cycle after `btn` is sampled high, `status` is 0 and the header search restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A link byte is present |
| in_byte | input | 8 | Link byte |
| rx_ready | output | 1 | The byte is taken when `in_valid` is also high |
| word_valid | output | 1 | One-cycle pulse for a payload word |
| word_data | output | 32 | Payload word |
| blk_go | output | 1 | Request to the flash sequencer |
| blk_op | output | 2 | Requested operation: 1 erase, 2 write, 3 verify |
| blk_addr | output | 32 | Block address for the request |
| blk_done | input | 1 | The sequencer has finished the open request |
| btn | input | 1 | Operator acknowledge that clears an error |
| status | output | 4 | Phase or error code for the display |

## Verification
The bench sends a header with a repeated first character. A framer that resynchronised on the offending byte would start a verify run and show status 2 instead of staying idle. It sends little-endian offsets that are valid only when decoded in the right byte order. It also checks a count that ends exactly at the last block next to one that runs one block past it, so that a wrong byte order or an off-by-one range test turns into a spurious error or a missing one. The payload words are chosen so that the checksum wraps past 2^32, which catches an accumulator that is too narrow or that saturates. A corrupted checksum must give status 8 with no write request, and a request must not change address or operation before `blk_done`.

// File: rtl/upg_pkg.sv
package upg_pkg;

   typedef enum logic [3:0] {
      S_HDR, S_CMD, S_OFF, S_CNT, S_ERASE, S_READ, S_CSUM, S_WRITE, S_VERIFY, S_ERR
   } upg_state_t;

   localparam logic [3:0] ST_IDLE  = 4'd0;
   localparam logic [3:0] ST_PROG  = 4'd1;
   localparam logic [3:0] ST_VERI  = 4'd2;
   localparam logic [3:0] ST_READ  = 4'd3;
   localparam logic [3:0] ST_WRITE = 4'd4;
   localparam logic [3:0] ST_CHECK = 4'd5;
   localparam logic [3:0] ST_E_OFF = 4'd6;
   localparam logic [3:0] ST_E_CNT = 4'd7;
   localparam logic [3:0] ST_E_SUM = 4'd8;

   localparam logic [1:0] OP_NONE  = 2'd0;
   localparam logic [1:0] OP_ERASE = 2'd1;
   localparam logic [1:0] OP_WRITE = 2'd2;
   localparam logic [1:0] OP_CHECK = 2'd3;

   localparam logic [7:0] CMD_PROG = 8'h50;
   localparam logic [7:0] CMD_VERI = 8'h56;

   function automatic logic [7:0] hdr_char(input logic [1:0] idx);
      case (idx)
         2'd0:    return 8'h4D;
         2'd1:    return 8'h50;
         2'd2:    return 8'h54;
         default: return 8'h21;
      endcase
   endfunction

endpackage

// File: rtl/upg_word_asm.sv
module upg_word_asm #(
   parameter int LANES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  logic [7:0]         byte_in,
   output logic [8*LANES-1:0] word_now,
   output logic               last
);
   localparam int CW = $clog2(LANES);

   logic [CW-1:0]        cnt;
   logic [8*LANES-9:0]   sh;

   assign word_now = {byte_in, sh};
   assign last     = take && (cnt == CW'(LANES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         sh  <= '0;
      end else if (take) begin
         cnt <= last ? '0 : cnt + 1'b1;
         sh  <= word_now[8*LANES-1:8];
      end
   end

endmodule

// File: rtl/upg_blk_sum.sv
module upg_blk_sum #(
   parameter int BLOCK_WORDS = 65536,
   parameter int WORD_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              add,
   input  logic [WORD_W-1:0] word,
   output logic [WORD_W-1:0] sum,
   output logic              at_last
);
   localparam int IDX_W = $clog2(BLOCK_WORDS);

   logic [IDX_W-1:0] idx;

   assign at_last = (idx == IDX_W'(BLOCK_WORDS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         sum <= '0;
         idx <= '0;
      end else if (add) begin
         sum <= sum + word;
         idx <= idx + 1'b1;
      end
   end

   assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (add && at_last && !clr) |=> !at_last || (BLOCK_WORDS == 1));

endmodule

// File: rtl/upg_range_chk.sv
module upg_range_chk #(
   parameter int BLK_SHIFT    = 18,
   parameter int ARRAY_BLOCKS = 64
) (
   input  logic [31:0] off,
   input  logic [7:0]  cnt,
   output logic        off_ok,
   output logic        cnt_ok
);
   localparam logic [32:0] ARR_BYTES = 33'(ARRAY_BLOCKS) << BLK_SHIFT;

   logic [32:0] blk_idx;
   logic [32:0] blk_end;

   assign blk_idx = {1'b0, off} >> BLK_SHIFT;
   assign blk_end = blk_idx + 33'(cnt);
   assign off_ok  = ({1'b0, off} < ARR_BYTES) && (off[BLK_SHIFT-1:0] == '0);
   assign cnt_ok  = (cnt != 8'd0) && (blk_end <= 33'(ARRAY_BLOCKS));

endmodule

// File: rtl/upg_cmd_framer.sv
module upg_cmd_framer
   import upg_pkg::*;
#(
   parameter int          BLOCK_WORDS  = 65536,
   parameter int          ARRAY_BLOCKS = 64,
   parameter logic [31:0] BASE         = 32'h0000_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [7:0]  in_byte,
   output logic        rx_ready,
   output logic        word_valid,
   output logic [31:0] word_data,
   output logic        blk_go,
   output logic [1:0]  blk_op,
   output logic [31:0] blk_addr,
   input  logic        blk_done,
   input  logic        btn,
   output logic [3:0]  status
);
   localparam int          BLK_SHIFT = $clog2(BLOCK_WORDS) + 2;
   localparam logic [31:0] BLK_BYTES = 32'(1) << BLK_SHIFT;

   if (BLOCK_WORDS < 2 || (1 << $clog2(BLOCK_WORDS)) != BLOCK_WORDS) begin : g_bad_words
      $error("BLOCK_WORDS must be a power of two of at least 2");
   end
   if (ARRAY_BLOCKS < 1 || BLK_SHIFT + $clog2(ARRAY_BLOCKS + 1) > 32) begin : g_bad_array
      $error("array does not fit a 32-bit offset");
   end

   upg_state_t  state;
   logic [1:0]  hdr_idx;
   logic        prog;
   logic [31:0] off_r;
   logic [7:0]  cnt_r;
   logic [3:0]  err_r;

   logic        acc, take, wlast, add, clr, at_last, off_ok, cnt_ok;
   logic [31:0] wnow, sum;

   always_comb begin
      case (state)
         S_HDR, S_CMD, S_OFF, S_CNT, S_READ, S_CSUM: rx_ready = 1'b1;
         default:                                    rx_ready = 1'b0;
      endcase
   end

   assign acc  = in_valid && rx_ready;
   assign take = acc && (state == S_OFF || state == S_READ || state == S_CSUM);
   assign add  = (state == S_READ) && wlast;
   assign clr  = !(state == S_READ || state == S_CSUM);

   upg_word_asm #(.LANES(4)) u_asm (
      .clk(clk), .rst_n(rst_n), .take(take), .byte_in(in_byte),
      .word_now(wnow), .last(wlast)
   );

   upg_blk_sum #(.BLOCK_WORDS(BLOCK_WORDS), .WORD_W(32)) u_sum (
      .clk(clk), .rst_n(rst_n), .clr(clr), .add(add), .word(wnow),
      .sum(sum), .at_last(at_last)
   );

   upg_range_chk #(.BLK_SHIFT(BLK_SHIFT), .ARRAY_BLOCKS(ARRAY_BLOCKS)) u_rng (
      .off(state == S_OFF ? wnow : off_r), .cnt(in_byte),
      .off_ok(off_ok), .cnt_ok(cnt_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_HDR;
         hdr_idx <= 2'd0;
         prog    <= 1'b0;
         off_r   <= '0;
         cnt_r   <= '0;
         err_r   <= ST_IDLE;
      end else begin
         unique case (state)
            S_HDR: if (acc) begin
               if (in_byte == hdr_char(hdr_idx)) begin
                  hdr_idx <= hdr_idx + 1'b1;
                  if (hdr_idx == 2'd3) state <= S_CMD;
               end else begin
                  hdr_idx <= 2'd0;
               end
            end
            S_CMD: if (acc) begin
               if (in_byte == CMD_PROG) begin
                  prog  <= 1'b1;
                  state <= S_OFF;
               end else if (in_byte == CMD_VERI) begin
                  prog  <= 1'b0;
                  state <= S_OFF;
               end else begin
                  state <= S_HDR;
               end
            end
            S_OFF: if (wlast) begin
               off_r <= wnow;
               if (off_ok) begin
                  state <= S_CNT;
               end else begin
                  err_r <= ST_E_OFF;
                  state <= S_ERR;
               end
            end
            S_CNT: if (acc) begin
               cnt_r <= in_byte;
               if (!cnt_ok) begin
                  err_r <= ST_E_CNT;
                  state <= S_ERR;
               end else begin
                  state <= prog ? S_ERASE : S_READ;
               end
            end
            S_ERASE: if (blk_done) state <= S_READ;
            S_READ: if (wlast && at_last) state <= S_CSUM;
            S_CSUM: if (wlast) begin
               if (wnow == sum) begin
                  state <= prog ? S_WRITE : S_VERIFY;
               end else begin
                  err_r <= ST_E_SUM;
                  state <= S_ERR;
               end
            end
            S_WRITE: if (blk_done) state <= S_VERIFY;
            S_VERIFY: if (blk_done) begin
               off_r <= off_r + BLK_BYTES;
               cnt_r <= cnt_r - 1'b1;
               if (cnt_r == 8'd1) state <= S_HDR;
               else               state <= prog ? S_ERASE : S_READ;
            end
            S_ERR: if (btn) begin
               hdr_idx <= 2'd0;
               state   <= S_HDR;
            end
            default: state <= S_HDR;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_valid <= 1'b0;
         word_data  <= '0;
      end else begin
         word_valid <= add;
         if (add) word_data <= wnow;
      end
   end

   always_comb begin
      blk_go = 1'b1;
      case (state)
         S_ERASE:  blk_op = OP_ERASE;
         S_WRITE:  blk_op = OP_WRITE;
         S_VERIFY: blk_op = OP_CHECK;
         default: begin
            blk_op = OP_NONE;
            blk_go = 1'b0;
         end
      endcase
   end

   assign blk_addr = BASE + off_r;

   always_comb begin
      case (state)
         S_OFF, S_CNT, S_ERASE: status = prog ? ST_PROG : ST_VERI;
         S_READ, S_CSUM:        status = ST_READ;
         S_WRITE:               status = ST_WRITE;
         S_VERIFY:              status = ST_CHECK;
         S_ERR:                 status = err_r;
         default:               status = ST_IDLE;
      endcase
   end

   assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_go && !blk_done) |=> (blk_go && $stable(blk_addr) && $stable(blk_op)));

   assert_no_rx_in_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
      blk_go |-> !rx_ready);

   assert_word_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> ($past(status) == ST_READ));

   assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (status >= ST_E_OFF && !btn) |=> $stable(status));

   assert_err_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (status >= ST_E_OFF && btn) |=> (status == ST_IDLE));

   assert_no_write_after_bad_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status == ST_E_SUM) |-> !blk_go);

endmodule

// File: tb/tb_upg_cmd_framer.sv
module tb_upg_cmd_framer;
   localparam int          BW   = 4;
   localparam int          NBLK = 64;
   localparam logic [31:0] BASE = 32'h8000_0000;
   localparam logic [31:0] BSZ  = 32'(BW * 4);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        rx_ready, word_valid, blk_go, blk_done = 1'b0, btn = 1'b0;
   logic [31:0] word_data, blk_addr;
   logic [1:0]  blk_op;
   logic [3:0]  status;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   logic [31:0] wq[$];
   logic [1:0]  opq[$];
   logic [31:0] adq[$];

   always #4 clk = ~clk;

   upg_cmd_framer #(.BLOCK_WORDS(BW), .ARRAY_BLOCKS(NBLK), .BASE(BASE)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .rx_ready(rx_ready), .word_valid(word_valid), .word_data(word_data),
      .blk_go(blk_go), .blk_op(blk_op), .blk_addr(blk_addr), .blk_done(blk_done),
      .btn(btn), .status(status)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         chk(1'b0, "watchdog", 32'(cyc), 32'd0);
         summary();
         $finish;
      end
   end

   // monitor: payload words against the scoreboard (R6)
   always @(negedge clk) begin
      if (rst_n && word_valid) begin
         if (wq.size() == 0) chk(1'b0, "R6 unexpected word", word_data, 32'h0);
         else begin
            logic [31:0] e;
            e = wq.pop_front();
            chk(word_data == e, "R6 word", word_data, e);
         end
      end
   end

   // flash sequencer model: checks requests (R8, R9), answers after a delay
   bit busy = 1'b0;
   int dly = 0;
   always @(negedge clk) begin
      if (blk_done) begin
         blk_done = 1'b0;
         busy = 1'b0;
      end else if (blk_go && !busy) begin
         logic [3:0] est;
         busy = 1'b1;
         dly = 3;
         if (opq.size() == 0) chk(1'b0, "R8 unexpected request", 32'(blk_op), 32'h0);
         else begin
            logic [1:0]  eo;
            logic [31:0] ea;
            eo = opq.pop_front();
            ea = adq.pop_front();
            chk(blk_op == eo, "R8 op", 32'(blk_op), 32'(eo));
            chk(blk_addr == ea, "R9 addr", blk_addr, ea);
            est = (eo == 2'd1) ? 4'd1 : (eo == 2'd2) ? 4'd4 : 4'd5;
            chk(status == est, "R8 status", 32'(status), 32'(est));
         end
      end else if (busy) begin
         dly--;
         if (dly == 0) blk_done = 1'b1;
      end
   end

   task automatic send_byte(input logic [7:0] b);
      while (!rx_ready) @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_word(input logic [31:0] w);
      for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
   endtask

   task automatic send_hdr(input logic [7:0] cmd);
      send_byte(8'h4D); send_byte(8'h50); send_byte(8'h54); send_byte(8'h21);
      send_byte(cmd);
   endtask

   // one block: pushes expectations, sends data and a good or bad checksum
   task automatic do_block(input bit prog, input logic [31:0] addr, input int seed, input bit bad);
      logic [31:0] s;
      s = 32'h0;
      if (prog) begin opq.push_back(2'd1); adq.push_back(addr); end
      for (int i = 0; i < BW; i++) wq.push_back(32'hE000_0000 + 32'(seed * 4 + i) * 32'h1357_9BDF);
      if (!bad) begin
         if (prog) begin opq.push_back(2'd2); adq.push_back(addr); end
         opq.push_back(2'd3); adq.push_back(addr);
      end
      for (int i = 0; i < BW; i++) begin
         logic [31:0] w;
         w = 32'hE000_0000 + 32'(seed * 4 + i) * 32'h1357_9BDF;
         s = s + w;
         send_word(w);
      end
      send_word(bad ? s ^ 32'h1 : s);
   endtask

   task automatic wait_status(input logic [3:0] exp);
      for (int i = 0; i < 400 && status != exp; i++) @(negedge clk);
   endtask

   task automatic release_err(input logic [3:0] code, input string req);
      @(negedge clk);
      chk(status == code, req, 32'(status), 32'(code));
      chk(rx_ready == 1'b0, "R11 rx held", 32'(rx_ready), 32'h0);
      repeat (10) @(negedge clk);
      chk(status == code, "R11 hold", 32'(status), 32'(code));
      btn = 1'b1;
      @(negedge clk);
      btn = 1'b0;
      chk(status == 4'd0, "R11 release", 32'(status), 32'h0);
   endtask

   task automatic drained(input string req);
      chk(wq.size() == 0 && opq.size() == 0, req, 32'(wq.size() + opq.size()), 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(status == 4'd0, "R1 status", 32'(status), 32'h0);
      chk(!blk_go && !word_valid, "R1 outputs", {blk_go, word_valid}, 32'h0);
      chk(rx_ready == 1'b1, "R1 rx_ready", 32'(rx_ready), 32'h1);

      // R2: second 'M' breaks the header and is not reused
      send_byte(8'h4D);
      send_hdr(8'h56);
      @(negedge clk);
      chk(status == 4'd0, "R2 resync", 32'(status), 32'h0);

      // R3: unknown opcode returns to search; a following 0x50 starts nothing
      send_hdr(8'h58);
      send_byte(8'h50);
      @(negedge clk);
      chk(status == 4'd0, "R3 bad opcode", 32'(status), 32'h0);

      // R3 R4 R5 R6 R7 R9 R10: verify, two blocks ending at the array end
      send_hdr(8'h56);
      @(negedge clk);
      chk(status == 4'd2, "R3 verify begun", 32'(status), 32'h2);
      send_word(32'h0000_03E0);
      send_byte(8'd2);
      @(negedge clk);
      chk(status == 4'd3, "R6 reading", 32'(status), 32'h3);
      do_block(1'b0, BASE + 32'h3E0, 1, 1'b0);
      do_block(1'b0, BASE + 32'h3E0 + BSZ, 2, 1'b0);
      wait_status(4'd0);
      chk(status == 4'd0, "R10 idle after run", 32'(status), 32'h0);
      drained("R10 drained");

      // R8: program, one block at offset 0x20
      send_hdr(8'h50);
      @(negedge clk);
      chk(status == 4'd1, "R3 program begun", 32'(status), 32'h1);
      send_word(32'h0000_0020);
      send_byte(8'd1);
      do_block(1'b1, BASE + 32'h20, 7, 1'b0);
      wait_status(4'd0);
      drained("R8 program drained");

      // R4: misaligned and out-of-range offsets
      send_hdr(8'h56);
      send_word(32'h0000_0024);
      release_err(4'd6, "R4 misaligned");
      send_hdr(8'h56);
      send_word(32'h0000_0400);
      release_err(4'd6, "R4 too large");

      // R5: zero count and one block past the end
      send_hdr(8'h56);
      send_word(32'h0000_0000);
      send_byte(8'd0);
      release_err(4'd7, "R5 zero count");
      send_hdr(8'h50);
      send_word(32'h0000_03E0);
      send_byte(8'd3);
      release_err(4'd7, "R5 past end");

      // R7: corrupted checksum in program mode
      send_hdr(8'h50);
      send_word(32'h0000_0100);
      send_byte(8'd1);
      do_block(1'b1, BASE + 32'h100, 9, 1'b1);
      release_err(4'd8, "R7 bad checksum");
      drained("R7 no write");

      summary();
      $finish;
   end

endmodule